// File: doc/BRIEF.md
# Parallel Fractional-Delay FIR Bank

This block delays a complex baseband stream by a selectable fraction of a sample. Every clock it can take one word of eight consecutive samples on each of the I and Q rails. It returns eight filtered samples per rail, so eight filter computations run in parallel, one for each lane position in the word. The filter is a 17-tap FIR with real 16-bit coefficients. I and Q go through separate but identical convolutions that share the same tap set. Across words the block keeps the most recent sixteen input samples of each rail. Only words flagged valid move that history forward.

The coefficients live in an on-chip bank of 32 sets. A 5-bit two's-complement delay code, from -16 to +15 and counting in steps of 1/32 sample, picks the set. The code is sampled together with each valid word, so the whole word is filtered with one set. Software computes the taps elsewhere and writes them one at a time through a load port. The set for code 0 is meant to hold the zero-fractional-delay filter. Its group delay of (TAPS-1)/2 = 8 samples is the common bulk latency that every other set also carries.

Top module: `frac_delay_fir`

## Requirements
- R1: During and after synchronous reset, out_valid is 0 and out_i/out_q are all zero. The sample history and every coefficient of the bank are cleared to zero, so the first valid word after reset is filtered against zero-valued older samples.
- R2: Lane j of a word occupies bits [16*j+15 : 16*j], and lane 0 is the oldest sample of the word. Output lane j equals round_sat(sum over k=0..16 of h[k]*x[n-k]), where x[n] is input lane j of the same word and x[n-1], x[n-2], ... run back through earlier lanes and then earlier valid words.
- R3: A cycle with in_valid low leaves the history unchanged, whatever is on in_i, in_q and delay_code.
- R4: I and Q are filtered independently with the same selected taps. Output I depends only on I inputs, and output Q depends only on Q inputs.
- R5: Coefficients are signed Q2.14, so 16384 means 1.0. The full-precision sum is rounded half up: add 8192, then shift right arithmetically by 14.
- R6: out_valid equals in_valid delayed by exactly two clock edges. out_i/out_q change only on edges that assert out_valid and otherwise hold their values.
- R7: delay_code is sampled on the edge that accepts a valid word. The code is used as the set address modulo 32 (code -16 is address 16). Consecutive words may use different codes, and each word is filtered only with its own set.
- R8: A clock with coef_we high writes coef_data into tap coef_tap of the set addressed by coef_code. Writes to taps 17 to 31 are dropped. A write leaves all other sets and taps unchanged.
- R9: If the code-0 set holds 16384 at tap 8 and zero elsewhere, the outputs reproduce the inputs exactly, delayed by eight samples (one word).
- R10: A rounded sum above 32767 saturates to 32767, and one below -32768 saturates to -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_i | input | 128 | Eight I samples, lane 0 oldest |
| in_q | input | 128 | Eight Q samples, lane 0 oldest |
| delay_code | input | 5 | Two's-complement fractional delay code for this word |
| coef_we | input | 1 | Coefficient write strobe |
| coef_code | input | 5 | Set address for the write |
| coef_tap | input | 5 | Tap index for the write (0 to 16) |
| coef_data | input | 16 | Signed Q2.14 coefficient |
| out_valid | output | 1 | Output word valid |
| out_i | output | 128 | Eight filtered I samples |
| out_q | output | 128 | Eight filtered Q samples |

## Verification
The assertions assume that reset is held for at least one edge and that a set is not rewritten while a word using that set is still in the two-stage pipeline. The stimulus keeps to this by loading coefficients only after several idle cycles. Between valid words it drives random garbage on the data and code inputs, so any leakage into the history shows up in the scoreboard. Codes change on every word in one phase. Full-scale inputs against large taps drive the sums past both saturation limits, and odd inputs against a half-valued tap land exactly on rounding ties of both signs.

// File: rtl/fdf_pkg.sv
`timescale 1ns/1ps
package fdf_pkg;
    parameter int unsigned LANES  = 8;
    parameter int unsigned TAPS   = 17;
    parameter int unsigned DW     = 16;
    parameter int unsigned CW     = 16;
    parameter int unsigned CODE_W = 5;
    parameter int unsigned FRAC   = 14;

    localparam int unsigned NSETS  = 1 << CODE_W;
    localparam int unsigned HIST   = TAPS - 1;
    localparam int unsigned WIN    = HIST + LANES;
    localparam int unsigned TAP_AW = $clog2(TAPS);
    localparam int unsigned PROD_W = DW + CW;
    localparam int unsigned ACC_W  = PROD_W + $clog2(TAPS);
    localparam int          SMP_MAX = (1 << (DW - 1)) - 1;
    localparam int          SMP_MIN = -(1 << (DW - 1));

    typedef logic signed [DW-1:0]     smp_t;
    typedef logic signed [CW-1:0]     coef_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        logic              we;
        logic [CODE_W-1:0] code;
        logic [TAP_AW-1:0] tap;
        coef_t             data;
    } coef_wr_t;

    // round half up at the binary point, then clamp to the sample range
    function automatic smp_t rnd_sat(input acc_t a);
        acc_t r;
        r = (a + acc_t'(1 <<< (FRAC - 1))) >>> FRAC;
        if (r > acc_t'(SMP_MAX))
            return smp_t'(SMP_MAX);
        else if (r < acc_t'(SMP_MIN))
            return smp_t'(SMP_MIN);
        else
            return smp_t'(r[DW-1:0]);
    endfunction
endpackage

// File: rtl/fdf_coef_bank.sv
`timescale 1ns/1ps
module fdf_coef_bank
    import fdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  coef_wr_t          wr,
    input  logic [CODE_W-1:0] rd_code,
    output coef_t             rd_taps [TAPS]
);
    coef_t mem [NSETS][TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++)
                for (int t = 0; t < TAPS; t++)
                    mem[s][t] <= '0;
        end else if (wr.we && (wr.tap < TAP_AW'(TAPS))) begin
            mem[wr.code][wr.tap] <= wr.data;
        end
    end

    always_comb begin
        for (int t = 0; t < TAPS; t++)
            rd_taps[t] = mem[rd_code][t];
    end

    // write observer for the load check
    logic              chk_we;
    logic [CODE_W-1:0] chk_code;
    logic [TAP_AW-1:0] chk_tap;
    coef_t             chk_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_we   <= 1'b0;
            chk_code <= '0;
            chk_tap  <= '0;
            chk_data <= '0;
        end else begin
            chk_we   <= wr.we && (wr.tap < TAP_AW'(TAPS));
            chk_code <= wr.code;
            chk_tap  <= wr.tap;
            chk_data <= wr.data;
        end
    end

    assert_load_R8: assert property (@(posedge clk) disable iff (rst)
        chk_we |-> (mem[chk_code][chk_tap] == chk_data));
endmodule

// File: rtl/fdf_history.sv
`timescale 1ns/1ps
module fdf_history
    import fdf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  smp_t new_s [LANES],
    output smp_t win   [WIN]
);
    smp_t hist [HIST];

    for (genvar p = 0; p < WIN; p++) begin : g_win
        if (p < HIST) begin : g_old
            assign win[p] = hist[p];
        end else begin : g_new
            assign win[p] = new_s[p - HIST];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < HIST; p++)
                hist[p] <= '0;
        end else if (in_valid) begin
            for (int p = 0; p < HIST; p++)
                hist[p] <= win[p + LANES];
        end
    end

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(hist[0]) && $stable(hist[HIST-1])));
endmodule

// File: rtl/fdf_lane_mac.sv
`timescale 1ns/1ps
module fdf_lane_mac
    import fdf_pkg::*;
#(
    parameter int unsigned LANE = 0
) (
    input  smp_t  win  [WIN],
    input  coef_t taps [TAPS],
    output smp_t  y
);
    acc_t  acc;
    prod_t prod;

    always_comb begin
        acc  = '0;
        prod = '0;
        for (int k = 0; k < TAPS; k++) begin
            prod = taps[k] * win[int'(HIST + LANE) - k];
            acc  = acc + acc_t'(prod);
        end
        y = rnd_sat(acc);
    end
endmodule

// File: rtl/frac_delay_fir.sv
`timescale 1ns/1ps
module frac_delay_fir
    import fdf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [LANES*DW-1:0]   in_i,
    input  logic [LANES*DW-1:0]   in_q,
    input  logic [CODE_W-1:0]     delay_code,
    input  logic                  coef_we,
    input  logic [CODE_W-1:0]     coef_code,
    input  logic [TAP_AW-1:0]     coef_tap,
    input  logic [CW-1:0]         coef_data,
    output logic                  out_valid,
    output logic [LANES*DW-1:0]   out_i,
    output logic [LANES*DW-1:0]   out_q
);
    smp_t     new_i [LANES];
    smp_t     new_q [LANES];
    smp_t     win_i [WIN];
    smp_t     win_q [WIN];
    coef_t    bank_taps [TAPS];
    coef_wr_t wr;

    for (genvar j = 0; j < LANES; j++) begin : g_unpack
        assign new_i[j] = in_i[j*DW +: DW];
        assign new_q[j] = in_q[j*DW +: DW];
    end

    assign wr = '{we: coef_we, code: coef_code, tap: coef_tap, data: coef_data};

    fdf_history u_hist_i (.clk(clk), .rst(rst), .in_valid(in_valid), .new_s(new_i), .win(win_i));
    fdf_history u_hist_q (.clk(clk), .rst(rst), .in_valid(in_valid), .new_s(new_q), .win(win_q));

    fdf_coef_bank u_bank (
        .clk(clk), .rst(rst), .wr(wr), .rd_code(delay_code), .rd_taps(bank_taps)
    );

    // stage 1: capture the window and the word's tap set
    logic  s1_valid;
    smp_t  s1_win_i [WIN];
    smp_t  s1_win_q [WIN];
    coef_t s1_taps  [TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            for (int p = 0; p < WIN; p++) begin
                s1_win_i[p] <= '0;
                s1_win_q[p] <= '0;
            end
            for (int t = 0; t < TAPS; t++)
                s1_taps[t] <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_win_i <= win_i;
                s1_win_q <= win_q;
                s1_taps  <= bank_taps;
            end
        end
    end

    // stage 2: eight parallel lanes per rail
    smp_t y_i [LANES];
    smp_t y_q [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        fdf_lane_mac #(.LANE(j)) u_mac_i (.win(s1_win_i), .taps(s1_taps), .y(y_i[j]));
        fdf_lane_mac #(.LANE(j)) u_mac_q (.win(s1_win_q), .taps(s1_taps), .y(y_q[j]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                for (int j = 0; j < LANES; j++) begin
                    out_i[j*DW +: DW] <= y_i[j];
                    out_q[j*DW +: DW] <= y_q[j];
                end
            end
        end
    end

    assert_accept_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_valid);
    assert_emit_R6: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> (!out_valid && $stable(out_i) && $stable(out_q)));
endmodule

// File: tb/test_frac_delay_fir.sv
`timescale 1ns/1ps
module test_frac_delay_fir;
    import fdf_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic [LANES*DW-1:0] in_i = '0;
    logic [LANES*DW-1:0] in_q = '0;
    logic [CODE_W-1:0]   delay_code = '0;
    logic                coef_we = 1'b0;
    logic [CODE_W-1:0]   coef_code = '0;
    logic [TAP_AW-1:0]   coef_tap = '0;
    logic [CW-1:0]       coef_data = '0;
    logic                out_valid;
    logic [LANES*DW-1:0] out_i;
    logic [LANES*DW-1:0] out_q;

    always #2.5 clk = ~clk;

    frac_delay_fir i_frac_delay_fir (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .delay_code(delay_code), .coef_we(coef_we), .coef_code(coef_code),
        .coef_tap(coef_tap), .coef_data(coef_data),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    int total = 0;
    int bad   = 0;
    int seed  = 32'h1234_5678;

    int ref_c  [NSETS][TAPS];
    int hist_i [HIST];
    int hist_q [HIST];

    logic [LANES*DW-1:0] eq_i [$];
    logic [LANES*DW-1:0] eq_q [$];
    string               tag_q [$];

    function automatic int rnd(input int span);
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) % span;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic ref_filter(input int code, input int d[LANES], inout int h[HIST],
                              output logic [LANES*DW-1:0] y);
        int     w [WIN];
        longint acc;
        for (int p = 0; p < WIN; p++)
            w[p] = (p < HIST) ? h[p] : d[p - HIST];
        for (int j = 0; j < LANES; j++) begin
            acc = 0;
            for (int k = 0; k < TAPS; k++)
                acc += longint'(ref_c[code & (NSETS - 1)][k]) * w[HIST + j - k];
            acc = (acc + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
            if (acc > SMP_MAX) acc = SMP_MAX;
            if (acc < SMP_MIN) acc = SMP_MIN;
            y[j*DW +: DW] = DW'(acc);
        end
        for (int p = 0; p < HIST; p++)
            h[p] = w[p + LANES];
    endtask

    task automatic drive_word(input int code, input int di[LANES], input int dq[LANES],
                              input string tag);
        logic [LANES*DW-1:0] yi, yq;
        ref_filter(code, di, hist_i, yi);
        ref_filter(code, dq, hist_q, yq);
        eq_i.push_back(yi);
        eq_q.push_back(yq);
        tag_q.push_back(tag);
        for (int j = 0; j < LANES; j++) begin
            in_i[j*DW +: DW] = DW'(di[j]);
            in_q[j*DW +: DW] = DW'(dq[j]);
        end
        delay_code = CODE_W'(code);
        in_valid   = 1'b1;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    task automatic rand_word(output int d[LANES], input int span);
        for (int j = 0; j < LANES; j++)
            d[j] = rnd(span);
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            in_valid   = 1'b0;
            in_i       = {4{32'(rnd(32'h7fff_ffff))}};
            in_q       = {4{32'(rnd(32'h7fff_ffff))}};
            delay_code = CODE_W'(rnd(32));
            @(negedge clk);
        end
    endtask

    task automatic load_set(input int code, input int vals[TAPS]);
        for (int t = 0; t < TAPS; t++) begin
            coef_we   = 1'b1;
            coef_code = CODE_W'(code);
            coef_tap  = TAP_AW'(t);
            coef_data = CW'(vals[t]);
            ref_c[code & (NSETS - 1)][t] = vals[t];
            @(negedge clk);
        end
        coef_we = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (eq_i.size() == 0) begin
                check(1'b0, "R6", "unexpected out_valid", 1, 0);
            end else begin
                logic [LANES*DW-1:0] xi, xq;
                string t;
                xi = eq_i.pop_front();
                xq = eq_q.pop_front();
                t  = tag_q.pop_front();
                total++;
                if (out_i !== xi || out_q !== xq) begin
                    bad++;
                    $display("FAIL %s word mismatch actual i=%h q=%h expected i=%h q=%h",
                             t, out_i, out_q, xi, xq);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", eq_i.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v [TAPS];
        int di [LANES];
        int dq [LANES];
        for (int s = 0; s < NSETS; s++)
            for (int t = 0; t < TAPS; t++)
                ref_c[s][t] = 0;
        for (int p = 0; p < HIST; p++) begin
            hist_i[p] = 0;
            hist_q[p] = 0;
        end

        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(out_i == '0 && out_q == '0, "R1", "outputs in reset", out_i[15:0], 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // coefficient sets
        for (int t = 0; t < TAPS; t++) v[t] = (t == HIST / 2) ? 16384 : 0;
        load_set(0, v);
        for (int t = 0; t < TAPS; t++) v[t] = rnd(6000);
        load_set(5, v);
        for (int t = 0; t < TAPS; t++) v[t] = rnd(6000);
        load_set(-16, v);
        for (int t = 0; t < TAPS; t++) v[t] = rnd(3000);
        load_set(3, v);
        for (int t = 0; t < TAPS; t++) v[t] = rnd(3000);
        load_set(4, v);
        for (int t = 0; t < TAPS; t++) v[t] = 30000;
        load_set(15, v);
        for (int t = 0; t < TAPS; t++) v[t] = (t == HIST / 2) ? 8192 : 0;
        load_set(7, v);
        // R8: out-of-range tap write must be dropped (set 0 stays an identity)
        coef_we = 1'b1; coef_code = '0; coef_tap = TAP_AW'(20); coef_data = 16'h1111;
        @(negedge clk);
        coef_we = 1'b0;
        idle(3);

        // R1: first word sees a zeroed history; R2 general filtering
        rand_word(di, 20000); rand_word(dq, 20000);
        drive_word(5, di, dq, "R1 first word after reset");
        for (int w = 0; w < 3; w++) begin
            rand_word(di, 20000); rand_word(dq, 20000);
            drive_word(5, di, dq, "R2 lane convolution");
        end
        // R3: gaps with garbage inputs
        idle(3);
        for (int w = 0; w < 3; w++) begin
            rand_word(di, 20000); rand_word(dq, 20000);
            drive_word(5, di, dq, "R3 history across gaps");
            idle(w + 1);
        end
        // R9 identity with code 0, R4 distinct rails
        for (int w = 0; w < 4; w++) begin
            rand_word(di, 32767); rand_word(dq, 32767);
            drive_word(0, di, dq, "R9 R4 zero-delay identity, independent rails");
        end
        for (int w = 0; w < 2; w++) begin
            rand_word(di, 30000);
            for (int j = 0; j < LANES; j++) dq[j] = 0;
            drive_word(5, di, dq, "R4 Q silent while I active");
        end
        // R7: code changes every word
        for (int w = 0; w < 8; w++) begin
            int codes [4] = '{0, 5, -16, 3};
            rand_word(di, 20000); rand_word(dq, 20000);
            drive_word(codes[w % 4], di, dq, "R7 per-word code switch");
        end
        // R5: rounding ties with a half-valued tap
        for (int w = 0; w < 3; w++) begin
            for (int j = 0; j < LANES; j++) begin
                di[j] = (j % 2 == 0) ? (2 * j + 1) : -(2 * j + 1);
                dq[j] = -di[j];
            end
            drive_word(7, di, dq, "R5 round half up");
        end
        // R10: saturation both ways
        for (int w = 0; w < 3; w++) begin
            for (int j = 0; j < LANES; j++) begin
                di[j] = 32767;
                dq[j] = -32768;
            end
            drive_word(15, di, dq, "R10 saturation");
        end
        rand_word(di, 32767); rand_word(dq, 32767);
        drive_word(15, di, dq, "R10 mixed saturation");

        // R8: rewrite set 4, set 3 must be untouched
        idle(4);
        for (int t = 0; t < TAPS; t++) v[t] = rnd(5000);
        load_set(4, v);
        idle(2);
        for (int w = 0; w < 3; w++) begin
            rand_word(di, 20000); rand_word(dq, 20000);
            drive_word(3, di, dq, "R8 untouched set");
            rand_word(di, 20000); rand_word(dq, 20000);
            drive_word(4, di, dq, "R8 rewritten set");
        end
        rand_word(di, 20000); rand_word(dq, 20000);
        drive_word(0, di, dq, "R8 dropped tap write");

        // R6: latency probe
        idle(4);
        rand_word(di, 20000); rand_word(dq, 20000);
        drive_word(5, di, dq, "R6 latency word");
        check(out_valid == 1'b0, "R6", "out_valid one edge after accept", out_valid, 0);
        idle(1);
        check(out_valid == 1'b1, "R6", "out_valid two edges after accept", out_valid, 1);
        idle(1);
        check(out_valid == 1'b0, "R6", "out_valid three edges after accept", out_valid, 0);

        idle(6);
        check(eq_i.size() == 0, "R6", "words left unanswered", eq_i.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule